// File: doc/BRIEF.md
# SMRAM and TSEG Access Controller

This block holds the two system-management memory control bytes and the extended TSEG size word. From them it decides, for every memory access, where the access lands. It covers three windows. The first is the legacy low SMRAM window at 0xA0000–0xBFFFF. The second is a high alias of that window at 0xFEDA0000–0xFEDBFFFF, which is remapped onto the legacy DRAM addresses. The third is the TSEG window just below the top of low memory. Each access carries a flag that says whether the requester is in system management mode (SMM). The block answers one cycle later with a route code: not claimed, DRAM, PCI, or black hole. A black-hole route means reads return 0xFFFFFFFF and writes are discarded.

Software programs the registers through a masked configuration write port. A sticky lock bit closes the open window and freezes most of the control bits until reset. The TSEG size comes from a 2-bit code. Three of the codes are fixed sizes, and the fourth uses a build-time extended size in MB. Firmware can discover that extended size by writing the query value into the extended word. An extended size above the parameter `EXT_TSEG_MAX` stops elaboration.

Top module: `smm_window_ctrl`

## Requirements
- R1: After reset the SMRAM control byte reads 0x02, the extended control byte reads 0x00, the extended word reads 0xFFFF when `EXT_TSEG_MB` > 0, and `resp_valid` is low.
- R2: A write selects a register through `cfg_sel`: 0 is the SMRAM control byte, 1 is the extended control byte, 2 is the extended word, and 3 touches nothing. Only bits set in both `cfg_wmask` and the register's write mask change. Unlocked, the write masks are 0x78 for the SMRAM byte (bit 6 open, bit 5 spare, bit 4 lock, bit 3 global enable) and 0x87 for the extended byte (bit 7 high-enable, bits 2:1 size code, bit 0 TSEG enable). Bits 2:0 of the SMRAM byte always read 010.
- R3: Once the lock bit (bit 4) is 1, the open bit (bit 6) reads 0, even when both are written 1 together. The lock bit stays set until reset. While locked, the SMRAM write mask is 0x20 and the extended byte cannot be written at all.
- R4: For a non-SMM access to the low window, the route is PCI (code 2) when open is 0. With open set, the route is PCI when high-enable is 1 and DRAM (code 1) when high-enable is 0.
- R5: For a non-SMM access to the high alias, the route is DRAM only when open and high-enable are both 1; otherwise it is not claimed (code 0). When the high alias routes to DRAM, `resp_addr` equals the address minus 0xFEDA0000 plus 0xA0000.
- R6: For an SMM access with global enable set, the low window goes to DRAM when high-enable is 0, and the high alias goes to DRAM when high-enable is 1. Otherwise the SMM access sees the non-SMM routing.
- R7: The TSEG size is 0 when TSEG enable is 0. Otherwise size code 00 gives 1 MB, 01 gives 2 MB, 10 gives 8 MB, and 11 gives `EXT_TSEG_MB` MB. `tseg_base` equals `low_mem_top` minus the size.
- R8: An access in [`tseg_base`, `low_mem_top`) with a nonzero size routes to DRAM for SMM and to the black hole (code 3) for non-SMM. Address `low_mem_top` itself and address `tseg_base`−1 are outside the window.
- R9: If a write leaves the extended word equal to 0xFFFF while `EXT_TSEG_MB` > 0, the word becomes `EXT_TSEG_MB`. Any other value written is kept as written.
- R10: An access presented in cycle N is answered in cycle N+1. The answer uses the registers as they stood before any write in cycle N. Addresses outside all windows route as not claimed, with `resp_addr` equal to the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select (0 SMRAM byte, 1 extended byte, 2 extended word) |
| cfg_wdata | input | 16 | Write data; the bytes use bits 7:0 |
| cfg_wmask | input | 16 | Per-bit write enable |
| low_mem_top | input | 32 | Size of memory below 4 GB |
| acc_valid | input | 1 | Access present |
| acc_addr | input | 32 | Access address |
| acc_smm | input | 1 | Requester is in SMM |
| resp_valid | output | 1 | Answer for the previous cycle's access |
| resp_route | output | 2 | 0 not claimed, 1 DRAM, 2 PCI, 3 black hole |
| resp_addr | output | 32 | Target address after alias remap |
| smram_ctl | output | 8 | SMRAM control byte readback |
| esmram_ctl | output | 8 | Extended control byte readback |
| ext_tseg_word | output | 16 | Extended TSEG word readback |
| tseg_base | output | 32 | Lowest TSEG address |

## Verification
A configuration write and an access can fall in the same cycle. The access must then be routed under the old register state. The bench provokes this with a directed step: a write that opens the window while high-enable is set, issued together with a high-alias access. The expected answer is "not claimed", and the same access one step later must go to DRAM. The random phase adds many more such collisions, because every step may carry both a write and an access. Each answer is judged against a model that applies the write only after it has computed the expected route.

// File: rtl/smm_pkg.sv
package smm_pkg;
    typedef enum logic [1:0] {
        RT_PASS = 2'd0,
        RT_DRAM = 2'd1,
        RT_PCI  = 2'd2,
        RT_ONES = 2'd3
    } route_e;

    localparam logic [1:0] SEL_CTL  = 2'd0;
    localparam logic [1:0] SEL_XCTL = 2'd1;
    localparam logic [1:0] SEL_EXTW = 2'd2;

    // control byte bit positions
    localparam int B_OPEN = 6;
    localparam int B_LOCK = 4;
    localparam int B_GEN  = 3;
    // extended control byte bit positions
    localparam int B_HIEN = 7;
    localparam int B_SZHI = 2;
    localparam int B_SZLO = 1;
    localparam int B_TEN  = 0;

    localparam logic [7:0] CTL_RST        = 8'h02;
    localparam logic [7:0] CTL_MASK       = 8'h78;
    localparam logic [7:0] CTL_MASK_LOCK  = 8'h20;
    localparam logic [7:0] XCTL_RST       = 8'h00;
    localparam logic [7:0] XCTL_MASK      = 8'h87;
    localparam logic [7:0] XCTL_MASK_LOCK = 8'h00;
    localparam logic [15:0] EXT_QUERY     = 16'hFFFF;

    typedef struct packed {
        logic [7:0]  ctl;
        logic [7:0]  xctl;
        logic [15:0] extw;
    } ctl_regs_t;

    typedef struct packed {
        logic        valid;
        route_e      route;
        logic [31:0] addr;
    } resp_t;
endpackage

// File: rtl/smm_ctl_regs.sv
module smm_ctl_regs
    import smm_pkg::*;
#(
    parameter int EXT_TSEG_MB = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_sel,
    input  logic [15:0] cfg_wdata,
    input  logic [15:0] cfg_wmask,
    output ctl_regs_t   regs_q
);
    localparam logic [15:0] EXT_VAL  = 16'(EXT_TSEG_MB);
    localparam logic [15:0] EXTW_RST = (EXT_TSEG_MB > 0) ? EXT_QUERY : 16'h0000;

    ctl_regs_t  regs_d;
    logic       locked;
    logic [7:0] bmask;

    always_comb begin
        regs_d = regs_q;
        locked = regs_q.ctl[B_LOCK];
        bmask  = 8'h00;
        if (cfg_we) begin
            case (cfg_sel)
                SEL_CTL: begin
                    bmask = (locked ? CTL_MASK_LOCK : CTL_MASK) & cfg_wmask[7:0];
                    regs_d.ctl = (regs_q.ctl & ~bmask) | (cfg_wdata[7:0] & bmask);
                end
                SEL_XCTL: begin
                    bmask = (locked ? XCTL_MASK_LOCK : XCTL_MASK) & cfg_wmask[7:0];
                    regs_d.xctl = (regs_q.xctl & ~bmask) | (cfg_wdata[7:0] & bmask);
                end
                SEL_EXTW: begin
                    regs_d.extw = (regs_q.extw & ~cfg_wmask) | (cfg_wdata & cfg_wmask);
                    if (EXT_TSEG_MB > 0 && regs_d.extw == EXT_QUERY) begin
                        regs_d.extw = EXT_VAL;
                    end
                end
                default: ;
            endcase
        end
        if (regs_d.ctl[B_LOCK]) begin
            regs_d.ctl[B_OPEN] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.ctl  <= CTL_RST;
            regs_q.xctl <= XCTL_RST;
            regs_q.extw <= EXTW_RST;
        end else begin
            regs_q <= regs_d;
        end
    end
endmodule

// File: rtl/smm_tseg_window.sv
module smm_tseg_window #(
    parameter int AW          = 32,
    parameter int EXT_TSEG_MB = 16
) (
    input  logic          t_en,
    input  logic [1:0]    sz_code,
    input  logic [AW-1:0] low_top,
    output logic [AW-1:0] size,
    output logic [AW-1:0] base
);
    localparam int MB_SHIFT = 20;
    localparam logic [AW-1:0] SZ_1M  = AW'(1) << MB_SHIFT;
    localparam logic [AW-1:0] SZ_2M  = AW'(2) << MB_SHIFT;
    localparam logic [AW-1:0] SZ_8M  = AW'(8) << MB_SHIFT;
    localparam logic [AW-1:0] SZ_EXT = AW'(EXT_TSEG_MB) << MB_SHIFT;

    always_comb begin
        if (!t_en) begin
            size = '0;
        end else begin
            case (sz_code)
                2'b00:   size = SZ_1M;
                2'b01:   size = SZ_2M;
                2'b10:   size = SZ_8M;
                default: size = SZ_EXT;
            endcase
        end
        base = low_top - size;
    end
endmodule

// File: rtl/smm_route_dec.sv
module smm_route_dec
    import smm_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic          smm,
    input  logic          open,
    input  logic          gen,
    input  logic          hien,
    input  logic [AW-1:0] tseg_size,
    input  logic [AW-1:0] tseg_base,
    input  logic [AW-1:0] low_top,
    output route_e        route,
    output logic [AW-1:0] xaddr
);
    localparam logic [AW-1:0] LOW_BASE  = AW'(32'h000A_0000);
    localparam logic [AW-1:0] WIN_SPAN  = AW'(32'h0002_0000);
    localparam logic [AW-1:0] HIGH_BASE = AW'(32'hFEDA_0000);

    logic   in_low, in_high, in_tseg;
    route_e plain;

    always_comb begin
        in_low  = (addr >= LOW_BASE) && (addr < LOW_BASE + WIN_SPAN);
        in_high = (addr >= HIGH_BASE) && (addr < HIGH_BASE + WIN_SPAN);
        in_tseg = (tseg_size != '0) && (addr >= tseg_base) && (addr < low_top);

        // view of a requester outside system management mode
        if (in_low) begin
            plain = (open && !hien) ? RT_DRAM : RT_PCI;
        end else if (in_high) begin
            plain = (open && hien) ? RT_DRAM : RT_PASS;
        end else if (in_tseg) begin
            plain = RT_ONES;
        end else begin
            plain = RT_PASS;
        end

        route = plain;
        if (smm) begin
            if (in_low && gen && !hien) begin
                route = RT_DRAM;
            end else if (in_high && gen && hien) begin
                route = RT_DRAM;
            end else if (!in_low && !in_high && in_tseg) begin
                route = RT_DRAM;
            end
        end

        xaddr = addr;
        if (in_high && route == RT_DRAM) begin
            xaddr = addr - HIGH_BASE + LOW_BASE;
        end
    end
endmodule

// File: rtl/smm_window_ctrl.sv
module smm_window_ctrl
    import smm_pkg::*;
#(
    parameter int EXT_TSEG_MB  = 16,
    parameter int EXT_TSEG_MAX = 4095
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_sel,
    input  logic [15:0] cfg_wdata,
    input  logic [15:0] cfg_wmask,
    input  logic [31:0] low_mem_top,
    input  logic        acc_valid,
    input  logic [31:0] acc_addr,
    input  logic        acc_smm,
    output logic        resp_valid,
    output logic [1:0]  resp_route,
    output logic [31:0] resp_addr,
    output logic [7:0]  smram_ctl,
    output logic [7:0]  esmram_ctl,
    output logic [15:0] ext_tseg_word,
    output logic [31:0] tseg_base
);
    localparam int AW = 32;

    if (EXT_TSEG_MB > EXT_TSEG_MAX) begin : g_bad_ext
        $error("EXT_TSEG_MB exceeds EXT_TSEG_MAX");
    end

    ctl_regs_t     regs_q;
    logic [AW-1:0] tsize, tbase, xaddr;
    route_e        route;
    resp_t         resp_d, resp_q;

    smm_ctl_regs #(.EXT_TSEG_MB(EXT_TSEG_MB)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_wmask (cfg_wmask),
        .regs_q    (regs_q)
    );

    smm_tseg_window #(.AW(AW), .EXT_TSEG_MB(EXT_TSEG_MB)) u_tseg (
        .t_en    (regs_q.xctl[B_TEN]),
        .sz_code (regs_q.xctl[B_SZHI:B_SZLO]),
        .low_top (low_mem_top),
        .size    (tsize),
        .base    (tbase)
    );

    smm_route_dec #(.AW(AW)) u_dec (
        .addr      (acc_addr),
        .smm       (acc_smm),
        .open      (regs_q.ctl[B_OPEN]),
        .gen       (regs_q.ctl[B_GEN]),
        .hien      (regs_q.xctl[B_HIEN]),
        .tseg_size (tsize),
        .tseg_base (tbase),
        .low_top   (low_mem_top),
        .route     (route),
        .xaddr     (xaddr)
    );

    always_comb begin
        resp_d.valid = acc_valid;
        resp_d.route = acc_valid ? route : RT_PASS;
        resp_d.addr  = acc_valid ? xaddr : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else begin
            resp_q <= resp_d;
        end
    end

    assign resp_valid    = resp_q.valid;
    assign resp_route    = resp_q.route;
    assign resp_addr     = resp_q.addr;
    assign smram_ctl     = regs_q.ctl;
    assign esmram_ctl    = regs_q.xctl;
    assign ext_tseg_word = regs_q.extw;
    assign tseg_base     = tbase;
endmodule

// File: rtl/smm_window_ctrl_chk.sv
module smm_window_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic [31:0] acc_addr,
    input logic        acc_smm,
    input logic        resp_valid,
    input logic [1:0]  resp_route,
    input logic [31:0] resp_addr,
    input logic [7:0]  smram_ctl,
    input logic [7:0]  esmram_ctl
);
    assert_lock_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        smram_ctl[4] |-> !smram_ctl[6]);

    assert_lock_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(smram_ctl[4]) |-> smram_ctl[4]);

    assert_xctl_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(smram_ctl[4]) |-> $stable(esmram_ctl));

    assert_ones_non_smm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && resp_valid && resp_route == 2'd3 |-> !$past(acc_smm));

    assert_resp_timing_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> resp_valid == $past(acc_valid));

    assert_alias_remap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && resp_valid && resp_route == 2'd1 && $past(acc_addr) >= 32'hFEDA_0000
            && $past(acc_addr) < 32'hFEDC_0000
        |-> resp_addr >= 32'h000A_0000 && resp_addr < 32'h000C_0000);
endmodule

bind smm_window_ctrl smm_window_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_addr   (acc_addr),
    .acc_smm    (acc_smm),
    .resp_valid (resp_valid),
    .resp_route (resp_route),
    .resp_addr  (resp_addr),
    .smram_ctl  (smram_ctl),
    .esmram_ctl (esmram_ctl)
);

// File: tb/tb_smm_window_ctrl.sv
`timescale 1ns/1ps
module tb_smm_window_ctrl;
    localparam int EXT = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd3;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_wmask = '0;
    logic [31:0] low_mem_top = 32'h8000_0000;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_smm = 1'b0;
    logic        resp_valid;
    logic [1:0]  resp_route;
    logic [31:0] resp_addr;
    logic [7:0]  smram_ctl;
    logic [7:0]  esmram_ctl;
    logic [15:0] ext_tseg_word;
    logic [31:0] tseg_base;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0]  m_ctl, m_xctl;
    logic [15:0] m_ext;

    always #10 clk = ~clk;

    smm_window_ctrl #(.EXT_TSEG_MB(EXT)) dut (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] tsz(input logic [7:0] x);
        if (!x[0]) return 32'd0;
        case (x[2:1])
            2'b00: return 32'd1 << 20;
            2'b01: return 32'd2 << 20;
            2'b10: return 32'd8 << 20;
            default: return 32'(EXT) << 20;
        endcase
    endfunction

    function automatic logic [1:0] exp_route(input logic [31:0] a, input bit smm);
        bit lo, hi, ts, op, g, h;
        lo = a >= 32'hA0000 && a <= 32'hBFFFF;
        hi = a >= 32'hFEDA0000 && a <= 32'hFEDBFFFF;
        ts = tsz(m_xctl) != 0 && a >= low_mem_top - tsz(m_xctl) && a < low_mem_top;
        op = m_ctl[6]; g = m_ctl[3]; h = m_xctl[7];
        if (lo) begin
            if (smm && g && !h) return 2'd1;
            return (op && !h) ? 2'd1 : 2'd2;
        end
        if (hi) begin
            if (smm && g && h) return 2'd1;
            return (op && h) ? 2'd1 : 2'd0;
        end
        if (ts) return smm ? 2'd1 : 2'd3;
        return 2'd0;
    endfunction

    function automatic string tag(input logic [31:0] a, input bit smm);
        if (a >= 32'hA0000 && a <= 32'hBFFFF) return smm ? "R6" : "R4";
        if (a >= 32'hFEDA0000 && a <= 32'hFEDBFFFF) return smm ? "R6" : "R5";
        if (a < low_mem_top && a >= low_mem_top - 32'h0100_0000) return "R8";
        return "R10";
    endfunction

    task automatic model_write(input logic [1:0] sel, input logic [15:0] wd, input logic [15:0] wm);
        logic [7:0] m;
        case (sel)
            2'd0: begin
                m = (m_ctl[4] ? 8'h20 : 8'h78) & wm[7:0];
                m_ctl = (m_ctl & ~m) | (wd[7:0] & m);
            end
            2'd1: begin
                m = (m_ctl[4] ? 8'h00 : 8'h87) & wm[7:0];
                m_xctl = (m_xctl & ~m) | (wd[7:0] & m);
            end
            2'd2: begin
                m_ext = (m_ext & ~wm) | (wd & wm);
                if (m_ext == 16'hFFFF) m_ext = 16'(EXT);
            end
            default: ;
        endcase
        if (m_ctl[4]) m_ctl[6] = 1'b0;
    endtask

    task automatic check_regs();
        chk(smram_ctl == m_ctl, "R2/R3 ctl", {24'd0, smram_ctl}, {24'd0, m_ctl});
        chk(esmram_ctl == m_xctl, "R2/R3 xctl", {24'd0, esmram_ctl}, {24'd0, m_xctl});
        chk(ext_tseg_word == m_ext, "R9", {16'd0, ext_tseg_word}, {16'd0, m_ext});
        chk(tseg_base == low_mem_top - tsz(m_xctl), "R7", tseg_base, low_mem_top - tsz(m_xctl));
    endtask

    // called at a falling edge; returns at the next falling edge after checking
    task automatic step(input bit we, input logic [1:0] sel, input logic [15:0] wd, input logic [15:0] wm,
                        input bit av, input logic [31:0] a, input bit smm);
        logic [1:0]  er;
        logic [31:0] ea;
        string t;
        cfg_we = we; cfg_sel = sel; cfg_wdata = wd; cfg_wmask = wm;
        acc_valid = av; acc_addr = a; acc_smm = smm;
        er = exp_route(a, smm);
        ea = (er == 2'd1 && a >= 32'hFEDA0000 && a <= 32'hFEDBFFFF) ? a - 32'hFEDA0000 + 32'hA0000 : a;
        t = tag(a, smm);
        if (we) model_write(sel, wd, wm);
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0; acc_valid = 1'b0;
        chk(resp_valid == av, "R10 valid", {31'd0, resp_valid}, {31'd0, av});
        if (av) begin
            chk(resp_route == er, t, {30'd0, resp_route}, {30'd0, er});
            chk(resp_addr == ea, t, resp_addr, ea);
        end
        check_regs();
    endtask

    task automatic do_reset(input logic [31:0] top);
        @(negedge clk);
        rst_n = 1'b0; cfg_we = 1'b0; acc_valid = 1'b0; low_mem_top = top;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_ctl = 8'h02; m_xctl = 8'h00; m_ext = (EXT > 0) ? 16'hFFFF : 16'h0;
        // R1 reset state
        chk(resp_valid == 1'b0, "R1 valid", {31'd0, resp_valid}, 32'd0);
        chk(smram_ctl == 8'h02, "R1 ctl", {24'd0, smram_ctl}, 32'h02);
        chk(esmram_ctl == 8'h00, "R1 xctl", {24'd0, esmram_ctl}, 32'h00);
        chk(ext_tseg_word == 16'hFFFF, "R1 ext", {16'd0, ext_tseg_word}, 32'hFFFF);
    endtask

    function automatic logic [31:0] pick_addr();
        logic [31:0] b;
        b = low_mem_top - tsz(m_xctl);
        case ($urandom % 8)
            0: return 32'hA0000 + ($urandom % 32'h20000);
            1: return 32'hFEDA0000 + ($urandom % 32'h20000);
            2: return b - 1 + ($urandom % 3);
            3: return low_mem_top - 1 + ($urandom % 3);
            4: return $urandom;
            5: case ($urandom % 4) 0: return 32'h9FFFF; 1: return 32'hA0000; 2: return 32'hBFFFF; default: return 32'hC0000; endcase
            6: case ($urandom % 4) 0: return 32'hFED9FFFF; 1: return 32'hFEDA0000; 2: return 32'hFEDBFFFF; default: return 32'hFEDC0000; endcase
            default: return b + ($urandom % (tsz(m_xctl) + 1));
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] tops[3];
        void'($urandom(32'd2718));
        tops[0] = 32'h8000_0000; tops[1] = 32'h4000_0000; tops[2] = 32'hB000_0000;

        do_reset(32'h8000_0000);
        // R7: TSEG with extended size code, high-enable set
        step(1, 2'd1, 16'h0087, 16'hFFFF, 1, 32'h7F00_0000, 0);
        chk(tseg_base == 32'h7F00_0000, "R7 ext size", tseg_base, 32'h7F00_0000);
        // R8 boundaries
        step(0, 2'd3, 0, 0, 1, 32'h7EFF_FFFF, 0);
        step(0, 2'd3, 0, 0, 1, 32'h7F00_0000, 0);
        chk(resp_route == 2'd3, "R8 base ones", {30'd0, resp_route}, 32'd3);
        step(0, 2'd3, 0, 0, 1, 32'h7FFF_FFFF, 1);
        step(0, 2'd3, 0, 0, 1, 32'h8000_0000, 0);
        // R9 query and plain write
        step(1, 2'd2, 16'h0005, 16'hFFFF, 0, 0, 0);
        step(1, 2'd2, 16'hFFFF, 16'hFFFF, 0, 0, 0);
        chk(ext_tseg_word == 16'(EXT), "R9 query", {16'd0, ext_tseg_word}, EXT);
        // R10: open written in the same cycle as a high-alias access
        step(1, 2'd0, 16'h0040, 16'h00FF, 1, 32'hFEDA_1234, 0);
        chk(resp_route == 2'd0, "R10 same cycle", {30'd0, resp_route}, 32'd0);
        step(0, 2'd3, 0, 0, 1, 32'hFEDA_1234, 0);
        chk(resp_addr == 32'h000A_1234, "R5 remap", resp_addr, 32'h000A_1234);
        // R6: global enable
        step(1, 2'd0, 16'h0008, 16'h00FF, 1, 32'hFEDB_0000, 1);
        step(0, 2'd3, 0, 0, 1, 32'h000B_0000, 1);
        // R3: lock together with open
        step(1, 2'd0, 16'h0050, 16'h00FF, 0, 0, 0);
        chk(smram_ctl == 8'h12, "R3 lock", {24'd0, smram_ctl}, 32'h12);
        step(1, 2'd0, 16'h0028, 16'h00FF, 0, 0, 0);
        chk(smram_ctl == 8'h32, "R3 locked mask", {24'd0, smram_ctl}, 32'h32);
        step(1, 2'd1, 16'h0000, 16'hFFFF, 1, 32'h000A_0000, 0);
        chk(esmram_ctl == 8'h87, "R3 xctl frozen", {24'd0, esmram_ctl}, 32'h87);

        for (int i = 0; i < 4000; i++) begin
            logic [31:0] a;
            if (i % 250 == 0) do_reset(tops[$urandom % 3]);
            a = pick_addr();
            step(($urandom % 3) == 0, 2'($urandom), 16'($urandom),
                 ($urandom % 2) ? 16'hFFFF : 16'($urandom),
                 ($urandom % 5) != 0, a, 1'($urandom));
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule